// File: doc/BRIEF.md
# Gated Commit Store Buffer

This block sits between an execution core and memory and holds the memory stores of an emulated program until software confirms them. Stores arrive in program order, each carrying a word address, write data and byte enables. They stay in the buffer as speculative entries and never reach memory on their own. When the controlling software decides the emulated state is coherent, it pulses a commit command. Every store then held becomes confirmed and is written out to memory, oldest first, through a valid/ready handshake.

If the software instead has to return to the last confirmed state, it pulses a rollback command. Every speculative store is dropped in one cycle. Confirmed stores that are still waiting to drain are not touched. A load port lets the core read its own pending writes: it searches both the speculative entries and the confirmed entries that have not yet drained. A full flag and a store-ready signal tell the core when no slot is free.

Top module: `gated_store_buffer`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty: st_ready is 1, full is 0, mem_valid is 0 and ld_hit is 0.
- R2: A store is taken on a clock edge where st_valid and st_ready are both 1, and it stays speculative. A speculative store never shows up on the memory port: mem_valid stays 0 while no commit has been given.
- R3: A commit pulse confirms every store taken before that edge, and mem_valid is 1 in the following cycle. A store taken on the same edge as the commit stays speculative.
- R4: A rollback pulse (with no commit) discards every speculative store, including one offered on the same edge. Discarded stores are never written to memory and no longer hit on loads. Confirmed entries still waiting to drain stay in the buffer and still drain.
- R5: Confirmed stores leave in the order they were taken, one per clock edge where mem_valid and mem_ready are both 1. While mem_valid is 1 and mem_ready is 0, mem_addr, mem_data and mem_be hold their values.
- R6: With DEPTH entries held (DEPTH defaults to 8), full is 1 and st_ready is 0. A store offered then is ignored: it is never written to memory and a load of its address does not hit on it.
- R7: A load compares address bits 31:2 (the word address) with every held entry, and the youngest matching entry is chosen. ld_hit is 1 and ld_data carries that entry's data only if its byte enables are all ones (4'b1111). Otherwise ld_hit is 0 and ld_data is 0. The result is combinational in the same cycle.
- R8: When commit and rollback are pulsed on the same edge, the commit takes effect and the rollback is ignored.
- R9: If the buffer is full and a memory handshake completes, st_ready is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | A free slot is available |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| cmd_commit | input | 1 | Confirm all held stores |
| cmd_rollback | input | 1 | Discard all speculative stores |
| ld_addr | input | 32 | Load lookup address |
| ld_hit | output | 1 | Lookup found a full-coverage youngest match |
| ld_data | output | 32 | Forwarded data, 0 on a miss |
| mem_valid | output | 1 | A confirmed store is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | 32 | Offered store address |
| mem_data | output | 32 | Offered store data |
| mem_be | output | 4 | Offered store byte enables |
| full | output | 1 | All DEPTH slots are occupied |

## Verification
Load lookups, st_ready and full are combinational from state registered at the previous edge, so they are compared in the same cycle that the stimulus is driven, at the falling edge. A commit is first visible on mem_valid one cycle after its edge, and a slot freed by a handshake is visible on st_ready one cycle after that handshake. The bench therefore drives each command just after a rising edge and checks the result at the falling edge of the following cycle. Memory writes are compared by a monitor at every falling edge where mem_valid and mem_ready are both high. Each write is matched against a queue of expected stores that the driver fills in the cycle it issues the commit, so the order in the queue is the order in which stores were confirmed.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int OFS_W     = $clog2(BE_W);
    localparam int DEF_DEPTH = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [BE_W-1:0]   be_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
        be_t   be;
    } store_t;

    // word-level address equality, byte offset ignored
    function automatic logic same_word(addr_t a, addr_t b);
        return a[ADDR_W-1:OFS_W] == b[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic full_cover(be_t be);
        return &be;
    endfunction
endpackage

// File: rtl/gsb_queue.sv
module gsb_queue
    import gsb_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  store_t           in_item,
    input  logic             do_commit,
    input  logic             do_rollback,
    input  logic             drain_fire,
    output logic             drain_avail,
    output store_t           age_ent [DEPTH],
    output logic [DEPTH-1:0] age_vld
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef logic [PW-1:0] ptr_t;
    typedef logic [CW-1:0] cnt_t;

    if ((1 << PW) != DEPTH) begin : g_depth_check
        $error("gsb_queue: DEPTH must be a power of two");
    end

    store_t slot_q [DEPTH];
    ptr_t   head_q, tail_q, head_n, tail_n;
    cnt_t   count_q, ccount_q, count_n, ccount_n;
    logic   push, pop, rb_eff;

    assign in_ready    = (count_q != cnt_t'(DEPTH));
    assign push        = in_valid && in_ready;
    assign drain_avail = (ccount_q != '0);
    assign pop         = drain_fire && drain_avail;
    // commit has priority over rollback
    assign rb_eff      = do_rollback && !do_commit;

    // Confirmed entries always form the oldest run starting at head,
    // so the boundary is a count rather than a bit per slot.
    always_comb begin
        head_n = head_q + ptr_t'(pop);
        if (rb_eff) begin
            tail_n  = head_q + ptr_t'(ccount_q);
            count_n = ccount_q - cnt_t'(pop);
        end else begin
            tail_n  = tail_q + ptr_t'(push);
            count_n = count_q + cnt_t'(push) - cnt_t'(pop);
        end
        ccount_n = (do_commit ? count_q : ccount_q) - cnt_t'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            tail_q   <= '0;
            count_q  <= '0;
            ccount_q <= '0;
        end else begin
            head_q   <= head_n;
            tail_q   <= tail_n;
            count_q  <= count_n;
            ccount_q <= ccount_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !rb_eff) begin
            slot_q[tail_q] <= in_item;
        end
    end

    // present entries oldest first
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        assign age_ent[i] = slot_q[ptr_t'(head_q + ptr_t'(i))];
        assign age_vld[i] = (cnt_t'(i) < count_q);
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count_q <= cnt_t'(DEPTH));

    assert_confirmed_subset_R2: assert property (@(posedge clk) disable iff (rst)
        ccount_q <= count_q);

    assert_commit_covers_R3: assert property (@(posedge clk) disable iff (rst)
        do_commit |=> (count_q - ccount_q) == cnt_t'($past(push)));

    assert_rollback_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (do_rollback && !do_commit) |=> (count_q == ccount_q));

    assert_slot_freed_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && drain_fire && drain_avail) |=> in_ready);
endmodule

// File: rtl/gsb_forward.sv
module gsb_forward
    import gsb_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  store_t           ent [DEPTH],
    input  logic [DEPTH-1:0] vld,
    input  addr_t            probe,
    output logic             hit,
    output data_t            data
);
    logic   found;
    store_t pick;

    // later (younger) matches override earlier ones
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && same_word(ent[i].addr, probe)) begin
                found = 1'b1;
                pick  = ent[i];
            end
        end
        hit  = found && full_cover(pick.be);
        data = hit ? pick.data : '0;
    end
endmodule

// File: rtl/gated_store_buffer.sv
module gated_store_buffer
    import gsb_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic              cmd_commit,
    input  logic              cmd_rollback,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              full
);
    store_t           in_item;
    store_t           age_ent [DEPTH];
    logic [DEPTH-1:0] age_vld;
    logic             drain_avail;

    assign in_item = '{addr: st_addr, data: st_data, be: st_be};

    gsb_queue #(.DEPTH(DEPTH)) queue_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (st_valid),
        .in_ready    (st_ready),
        .in_item     (in_item),
        .do_commit   (cmd_commit),
        .do_rollback (cmd_rollback),
        .drain_fire  (mem_ready),
        .drain_avail (drain_avail),
        .age_ent     (age_ent),
        .age_vld     (age_vld)
    );

    gsb_forward #(.DEPTH(DEPTH)) fwd_i (
        .ent   (age_ent),
        .vld   (age_vld),
        .probe (ld_addr),
        .hit   (ld_hit),
        .data  (ld_data)
    );

    assign mem_valid = drain_avail;
    assign mem_addr  = age_ent[0].addr;
    assign mem_data  = age_ent[0].data;
    assign mem_be    = age_ent[0].be;
    assign full      = !st_ready;

    assert_drain_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));
endmodule

// File: tb/gated_store_buffer_tb.sv
`timescale 1ns/1ps
module gated_store_buffer_tb_top;
    import gsb_pkg::*;
    localparam int DEPTH = DEF_DEPTH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic st_valid = 1'b0, cmd_commit = 1'b0, cmd_rollback = 1'b0, mem_ready = 1'b0;
    addr_t st_addr = '0, ld_addr = '0;
    data_t st_data = '0;
    be_t   st_be = '0;
    logic  st_ready, ld_hit, mem_valid, full;
    addr_t mem_addr;
    data_t mem_data;
    be_t   mem_be;

    int checks = 0;
    int errors = 0;
    bit rdy_next = 1'b0;
    bit finished = 1'b0;

    store_t pend_q[$];
    store_t exp_q[$];

    always #2 clk = ~clk;

    gated_store_buffer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .cmd_commit(cmd_commit), .cmd_rollback(cmd_rollback),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data_w),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .full(full)
    );
    data_t ld_data_w;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares every memory write with the expected queue
    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                chk("R4 unconfirmed store reached memory", mem_addr, 32'hFFFF_FFFF);
            end else begin
                store_t e;
                e = exp_q.pop_front();
                chk("R5 drain addr", mem_addr, e.addr);
                chk("R5 drain data", mem_data, e.data);
                chk("R5 drain be", {28'd0, mem_be}, {28'd0, e.be});
            end
        end
    end

    // driver: one clock edge of stimulus, model update, ready prediction
    task automatic cyc(input bit sv, input addr_t a, input data_t d, input be_t be,
                       input bit c, input bit r);
        bit pred;
        @(posedge clk); #1;
        st_valid = sv; st_addr = a; st_data = d; st_be = be;
        cmd_commit = c; cmd_rollback = r; mem_ready = rdy_next;
        pred = (pend_q.size() + exp_q.size()) < DEPTH;
        if (c) begin
            foreach (pend_q[k]) exp_q.push_back(pend_q[k]);
            pend_q.delete();
        end else if (r) begin
            pend_q.delete();
        end
        if (sv && pred && !(r && !c)) pend_q.push_back('{addr: a, data: d, be: be});
        @(negedge clk);
        chk("R6 st_ready", {31'd0, st_ready}, {31'd0, pred});
        chk("R6 full", {31'd0, full}, {31'd0, !pred});
    endtask

    task automatic store(input addr_t a, input data_t d, input be_t be);
        cyc(1'b1, a, d, be, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, '0, 1'b0, 1'b0);
    endtask

    // load lookup against the model (oldest confirmed first, then speculative)
    task automatic probe(input addr_t a, input string req);
        bit found;
        store_t pick;
        bit e_hit;
        data_t e_data;
        @(posedge clk); #1;
        st_valid = 0; cmd_commit = 0; cmd_rollback = 0; mem_ready = rdy_next;
        ld_addr = a;
        found = 0; pick = '0;
        foreach (exp_q[k]) if (exp_q[k].addr[31:2] == a[31:2]) begin found = 1; pick = exp_q[k]; end
        foreach (pend_q[k]) if (pend_q[k].addr[31:2] == a[31:2]) begin found = 1; pick = pend_q[k]; end
        e_hit  = found && (pick.be == 4'hF);
        e_data = e_hit ? pick.data : '0;
        @(negedge clk);
        chk({req, " ld_hit"}, {31'd0, ld_hit}, {31'd0, e_hit});
        chk({req, " ld_data"}, ld_data_w, e_data);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        addr_t hold_a;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 st_ready", {31'd0, st_ready}, 32'd1);
        chk("R1 full", {31'd0, full}, 32'd0);
        chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
        chk("R1 ld_hit", {31'd0, ld_hit}, 32'd0);

        // R2: speculative stores stay off the memory port
        rdy_next = 1;
        store(32'h100, 32'hAAAA_0001, 4'hF);
        store(32'h104, 32'hAAAA_0002, 4'hF);
        store(32'h108, 32'hAAAA_0003, 4'hF);
        idle(2);
        chk("R2 no drain without commit", {31'd0, mem_valid}, 32'd0);

        // R7: forwarding cases
        probe(32'h104, "R7 plain hit");
        store(32'h100, 32'hBBBB_0011, 4'hF);
        probe(32'h100, "R7 youngest wins");
        store(32'h104, 32'hCCCC_0022, 4'h3);
        probe(32'h104, "R7 partial youngest misses");
        probe(32'h10C, "R7 no match");
        probe(32'h101, "R7 byte offset ignored");

        // R3: commit then drain
        rdy_next = 0;
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(1);
        chk("R3 mem_valid after commit", {31'd0, mem_valid}, 32'd1);
        hold_a = mem_addr;
        idle(1);
        chk("R5 addr held while stalled", mem_addr, hold_a);
        rdy_next = 1;
        idle(8);

        // R4: rollback drops speculative, keeps confirmed
        rdy_next = 0;
        store(32'h200, 32'hDDDD_0001, 4'hF);
        cyc(1'b1, 32'h204, 32'hDDDD_0002, 4'hF, 1'b1, 1'b0);
        store(32'h208, 32'hDDDD_0003, 4'hF);
        cyc(1'b1, 32'h20C, 32'hDDDD_0004, 4'hF, 1'b0, 1'b1);
        probe(32'h204, "R4 discarded store misses");
        probe(32'h20C, "R4 same-edge store discarded");
        probe(32'h200, "R4 confirmed entry kept");
        rdy_next = 1;
        idle(4);
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(3);
        chk("R4 nothing left after rollback", {31'd0, mem_valid}, 32'd0);

        // R8: commit beats rollback
        store(32'h300, 32'hEEEE_0001, 4'hF);
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b1);
        idle(3);
        chk("R8 store drained", exp_q.size(), 32'd0);

        // R6 / R9: fill, refuse, free a slot
        rdy_next = 0;
        for (int i = 0; i < DEPTH; i++) store(32'h400 + 32'(4 * i), 32'h4400_0000 + 32'(i), 4'hF);
        store(32'h4F0, 32'h4F4F_4F4F, 4'hF);
        chk("R6 full flag", {31'd0, full}, 32'd1);
        probe(32'h4F0, "R6 refused store absent");
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b0);
        rdy_next = 1;
        idle(1);
        rdy_next = 0;
        idle(1);
        chk("R9 st_ready after handshake", {31'd0, st_ready}, 32'd1);
        store(32'h4F4, 32'h4F4F_0004, 4'hF);
        rdy_next = 1;
        idle(12);
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b0);
        idle(4);

        chk("R5 all confirmed drained", exp_q.size(), 32'd0);
        chk("R3 buffer idle at end", {31'd0, mem_valid}, 32'd0);
        finish_run();
    end
endmodule